// File: doc/BRIEF.md
# Processor Idle Disconnect Sequencer

This block lives in a system controller, next to the decoder for front-side bus special cycles. When a processor sends a Halt or a Stop Grant cycle, the block decides what happens next. In the plain path it sends a forward request to the PCI side and then returns to normal operation. In the low-power path it first takes the processor bus down. It drops its connect output and waits for the processor to lower ready. For Stop Grant it then asks the memory controller to enter self-refresh. Only after these steps does it forward the cycle.

One configuration input picks the Halt behaviour and another picks the Stop Grant behaviour. Stop Grant acts only after every processor named in the presence mask has sent its cycle. While the bus is down, the block watches for DMA traffic that needs a cache probe. For each such probe it raises connect again, waits for ready, and grants the probe. When the probe is done it takes the bus down again. Any other processor bus activity ends the low-power episode and returns the block to normal operation.

Top module: `cpu_idle_sequencer`

## Requirements
- R1: After reset, cpu_connect is 1 and sr_req, fwd_req and probe_go are 0.
- R2: A Halt cycle (sc_kind = 0) with cfg_halt_lp = 0 raises fwd_req with fwd_kind = 0 in the next cycle. cpu_connect stays 1 and sr_req stays 0. After fwd_ack the block is idle with connect high.
- R3: A Halt cycle with cfg_halt_lp = 1 drops cpu_connect in the next cycle. fwd_req with fwd_kind = 0 comes only after cpu_ready is low. sr_req is never raised. After fwd_ack the bus stays disconnected.
- R4: Stop Grant (sc_kind = 1) acts only once a cycle has arrived from every processor whose bit is set in cfg_cpu_mask, where bit i belongs to sc_cpu = i. A cycle from a processor outside the mask is ignored, and a repeat from the same processor does not count twice. The collected set empties when it completes, so the next round needs every processor again.
- R5: A completed Stop Grant with cfg_stpg_lp = 0 raises fwd_req with fwd_kind = 1 in the next cycle, and cpu_connect stays 1.
- R6: A completed Stop Grant with cfg_stpg_lp = 1 runs in a fixed order. cpu_connect drops first. Once cpu_ready is low, sr_req rises. fwd_req with fwd_kind = 1 follows only after sr_ack. After fwd_ack the bus stays disconnected, and sr_req and fwd_req are never high together.
- R7: sr_req stays high until sr_ack is seen. fwd_req and fwd_kind stay unchanged until fwd_ack is seen.
- R8: A probe_req while disconnected raises cpu_connect in the next cycle. probe_go rises only after cpu_ready is high, and stays high until probe_done.
- R9: After probe_done the block drops cpu_connect again and returns to the disconnected state without raising sr_req or fwd_req a second time.
- R10: A bus_activity pulse while disconnected, or during a probe, reconnects the processor. The block then returns to normal operation with cpu_connect high and no request pending.
- R11: While cpu_connect is low and cpu_ready is still high, neither sr_req nor fwd_req rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_halt_lp | input | 1 | 1: Halt takes the disconnect path |
| cfg_stpg_lp | input | 1 | 1: Stop Grant takes the disconnect and self-refresh path |
| cfg_cpu_mask | input | NUM_CPU | Installed processors, bit i = processor i |
| sc_valid | input | 1 | Special cycle decoded this cycle |
| sc_kind | input | 1 | 0 = Halt, 1 = Stop Grant |
| sc_cpu | input | IDX_W | Index of the processor that issued the cycle |
| bus_activity | input | 1 | Processor bus activity other than a probe |
| cpu_ready | input | 1 | Ready from the processor |
| cpu_connect | output | 1 | Connect to the processor |
| sr_req | output | 1 | Self-refresh request, held until acknowledged |
| sr_ack | input | 1 | Self-refresh acknowledge |
| fwd_req | output | 1 | Forward request to the PCI side, held until acknowledged |
| fwd_kind | output | 1 | Kind of cycle being forwarded, 0 = Halt, 1 = Stop Grant |
| fwd_ack | input | 1 | Forward acknowledge |
| probe_req | input | 1 | DMA request that needs a processor cache probe |
| probe_done | input | 1 | Probe finished |
| probe_go | output | 1 | Probe may proceed, the processor is connected |

## Verification
The assertions assume a well-behaved environment. sr_ack and fwd_ack are raised only while their request is high. cpu_ready eventually follows cpu_connect. The presence mask is never zero. Special cycles arrive only while the processor is connected and the block is idle or collecting. The bench keeps to all of this: its responder copies each request onto its acknowledge and ready onto connect at the falling edge. It sends special cycles only after the previous episode has ended. The directed tests hold ready or an acknowledge back on purpose, for a few cycles, to open the waiting windows.

// File: rtl/cis_pkg.sv
// Shared types for the processor idle disconnect sequencer.
// Assumes: one special cycle kind bit, 0 for Halt and 1 for Stop Grant.
package cis_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_DISC_REQ,
        ST_DISCONNECTED,
        ST_SR_REQ,
        ST_FWD,
        ST_RECONN,
        ST_PROBE
    } seq_state_t;

    localparam logic KIND_HALT = 1'b0;
    localparam logic KIND_STPG = 1'b1;
endpackage

// File: rtl/cis_stpg_collect.sv
// Collects Stop Grant arrivals, one flag per processor.
// Assumes: arrive is gated by the sequencer, mask is nonzero.
// set_done pulses in the cycle the last present processor arrives, and the flags then clear.
module cis_stpg_collect #(
    parameter int NUM_CPU = 2,
    parameter int IDX_W   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CPU-1:0] mask,
    input  logic               arrive,
    input  logic [IDX_W-1:0]   arrive_cpu,
    output logic               set_done
);
    logic [NUM_CPU-1:0] seen_q;
    logic [NUM_CPU-1:0] hit;

    // Per-processor flag including the current arrival, masked by presence.
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_hit
        assign hit[i] = mask[i] & (seen_q[i] | (arrive && (arrive_cpu == IDX_W'(i))));
    end

    assign set_done = arrive && (hit == mask) && (|mask);

    // Flag register: emptied on completion, merged on every other arrival.
    always_ff @(posedge clk) begin
        if (!rst_n)        seen_q <= '0;
        else if (set_done) seen_q <= '0;
        else if (arrive)   seen_q <= hit;
    end
endmodule

// File: rtl/cis_fsm.sv
// Main sequencer: forward path, disconnect handshake, self-refresh, probe reconnect.
// Assumes: acks only while the matching request is high, ready eventually follows connect.
// Outputs are decoded from the state register, so each follows its transition by one edge.
module cis_fsm
    import cis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_halt_lp,
    input  logic cfg_stpg_lp,
    input  logic sc_valid,
    input  logic sc_kind,
    input  logic stpg_done,
    input  logic bus_activity,
    input  logic cpu_ready,
    input  logic sr_ack,
    input  logic fwd_ack,
    input  logic probe_req,
    input  logic probe_done,
    output logic accept_stpg,
    output logic cpu_connect,
    output logic sr_req,
    output logic fwd_req,
    output logic fwd_kind,
    output logic probe_go
);
    seq_state_t state_q, state_d;
    logic lp_q, lp_d, kind_q, kind_d;
    logic sr_pend_q, sr_pend_d, fwd_pend_q, fwd_pend_d, wake_q, wake_d;
    logic open_st;

    assign open_st     = (state_q == ST_IDLE) || (state_q == ST_COLLECT);
    assign accept_stpg = open_st && sc_valid && (sc_kind == KIND_STPG);

    // Next-state and sequencing flags.
    always_comb begin
        state_d    = state_q;
        lp_d       = lp_q;
        kind_d     = kind_q;
        sr_pend_d  = sr_pend_q;
        fwd_pend_d = fwd_pend_q;
        wake_d     = wake_q;
        unique case (state_q)
            ST_IDLE, ST_COLLECT: begin
                if (state_q == ST_IDLE && sc_valid && sc_kind == KIND_HALT) begin
                    kind_d     = KIND_HALT;
                    lp_d       = cfg_halt_lp;
                    sr_pend_d  = 1'b0;
                    fwd_pend_d = 1'b1;
                    state_d    = cfg_halt_lp ? ST_DISC_REQ : ST_FWD;
                end else if (stpg_done) begin
                    kind_d     = KIND_STPG;
                    lp_d       = cfg_stpg_lp;
                    sr_pend_d  = cfg_stpg_lp;
                    fwd_pend_d = 1'b1;
                    state_d    = cfg_stpg_lp ? ST_DISC_REQ : ST_FWD;
                end else if (accept_stpg) begin
                    state_d = ST_COLLECT;
                end
            end
            ST_DISC_REQ: begin
                if (!cpu_ready)
                    state_d = sr_pend_q ? ST_SR_REQ : (fwd_pend_q ? ST_FWD : ST_DISCONNECTED);
            end
            ST_SR_REQ: begin
                if (sr_ack) begin
                    sr_pend_d = 1'b0;
                    state_d   = ST_FWD;
                end
            end
            ST_FWD: begin
                if (fwd_ack) begin
                    fwd_pend_d = 1'b0;
                    state_d    = lp_q ? ST_DISCONNECTED : ST_IDLE;
                end
            end
            ST_DISCONNECTED: begin
                if (bus_activity) begin
                    wake_d  = 1'b1;
                    state_d = ST_RECONN;
                end else if (probe_req) begin
                    state_d = ST_RECONN;
                end
            end
            ST_RECONN: begin
                if (bus_activity) wake_d = 1'b1;
                if (cpu_ready) begin
                    if (wake_q || bus_activity) begin
                        wake_d  = 1'b0;
                        lp_d    = 1'b0;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_PROBE;
                    end
                end
            end
            ST_PROBE: begin
                if (bus_activity) wake_d = 1'b1;
                if (probe_done) begin
                    if (wake_q || bus_activity) begin
                        wake_d  = 1'b0;
                        lp_d    = 1'b0;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_DISC_REQ;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and flag registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lp_q       <= 1'b0;
            kind_q     <= KIND_HALT;
            sr_pend_q  <= 1'b0;
            fwd_pend_q <= 1'b0;
            wake_q     <= 1'b0;
        end else begin
            state_q    <= state_d;
            lp_q       <= lp_d;
            kind_q     <= kind_d;
            sr_pend_q  <= sr_pend_d;
            fwd_pend_q <= fwd_pend_d;
            wake_q     <= wake_d;
        end
    end

    // Output decode from the registered state.
    always_comb begin
        cpu_connect = !((state_q == ST_DISC_REQ) || (state_q == ST_DISCONNECTED) ||
                        (state_q == ST_SR_REQ) || ((state_q == ST_FWD) && lp_q));
        sr_req   = (state_q == ST_SR_REQ);
        fwd_req  = (state_q == ST_FWD);
        fwd_kind = kind_q;
        probe_go = (state_q == ST_PROBE);
    end
endmodule

// File: rtl/cpu_idle_sequencer.sv
// Top level: wires the Stop Grant collector to the sequencer.
// Assumes: special cycles are presented one per cycle with the issuing processor index.
module cpu_idle_sequencer #(
    parameter int  NUM_CPU = 2,
    localparam int IDX_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_halt_lp,
    input  logic               cfg_stpg_lp,
    input  logic [NUM_CPU-1:0] cfg_cpu_mask,
    input  logic               sc_valid,
    input  logic               sc_kind,
    input  logic [IDX_W-1:0]   sc_cpu,
    input  logic               bus_activity,
    input  logic               cpu_ready,
    output logic               cpu_connect,
    output logic               sr_req,
    input  logic               sr_ack,
    output logic               fwd_req,
    output logic               fwd_kind,
    input  logic               fwd_ack,
    input  logic               probe_req,
    input  logic               probe_done,
    output logic               probe_go
);
    logic accept_stpg;
    logic stpg_done;

    cis_stpg_collect #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask       (cfg_cpu_mask),
        .arrive     (accept_stpg),
        .arrive_cpu (sc_cpu),
        .set_done   (stpg_done)
    );

    cis_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_halt_lp  (cfg_halt_lp),
        .cfg_stpg_lp  (cfg_stpg_lp),
        .sc_valid     (sc_valid),
        .sc_kind      (sc_kind),
        .stpg_done    (stpg_done),
        .bus_activity (bus_activity),
        .cpu_ready    (cpu_ready),
        .sr_ack       (sr_ack),
        .fwd_ack      (fwd_ack),
        .probe_req    (probe_req),
        .probe_done   (probe_done),
        .accept_stpg  (accept_stpg),
        .cpu_connect  (cpu_connect),
        .sr_req       (sr_req),
        .fwd_req      (fwd_req),
        .fwd_kind     (fwd_kind),
        .probe_go     (probe_go)
    );
endmodule

// File: rtl/cis_checker.sv
// Port-level properties of the sequencer, bound into every instance of the top.
// Assumes: acks only while requests are high, as in the brief.
module cis_checker (
    input logic clk,
    input logic rst_n,
    input logic cpu_ready,
    input logic cpu_connect,
    input logic sr_req,
    input logic sr_ack,
    input logic fwd_req,
    input logic fwd_kind,
    input logic fwd_ack,
    input logic probe_done,
    input logic probe_go
);
    AST_SR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_req && !sr_ack) |=> sr_req); // R7
    AST_FWD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_req && !fwd_ack) |=> (fwd_req && $stable(fwd_kind))); // R7
    AST_SR_WHILE_DISC: assert property (@(posedge clk) disable iff (!rst_n)
        sr_req |-> !cpu_connect); // R6
    AST_SR_FWD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sr_req && fwd_req)); // R6
    AST_PROBE_CONNECTED: assert property (@(posedge clk) disable iff (!rst_n)
        probe_go |-> cpu_connect); // R8
    AST_PROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_go && !probe_done) |=> probe_go); // R8
    AST_WAIT_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_connect && cpu_ready && !sr_req && !fwd_req) |=> (!sr_req && !fwd_req)); // R11
endmodule

bind cpu_idle_sequencer cis_checker u_chk (.*);

// File: tb/cpu_idle_sequencer_tb.sv
module cpu_idle_sequencer_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_halt_lp = 1'b0, cfg_stpg_lp = 1'b0;
    logic [1:0] cfg_cpu_mask = 2'b11;
    logic sc_valid = 1'b0, sc_kind = 1'b0;
    logic [0:0] sc_cpu = 1'b0;
    logic bus_activity = 1'b0, cpu_ready = 1'b1;
    logic sr_ack = 1'b0, fwd_ack = 1'b0, probe_req = 1'b0, probe_done = 1'b0;
    logic cpu_connect, sr_req, fwd_req, fwd_kind, probe_go;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_idle_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_halt_lp(cfg_halt_lp), .cfg_stpg_lp(cfg_stpg_lp),
        .cfg_cpu_mask(cfg_cpu_mask), .sc_valid(sc_valid), .sc_kind(sc_kind), .sc_cpu(sc_cpu),
        .bus_activity(bus_activity), .cpu_ready(cpu_ready), .cpu_connect(cpu_connect),
        .sr_req(sr_req), .sr_ack(sr_ack), .fwd_req(fwd_req), .fwd_kind(fwd_kind),
        .fwd_ack(fwd_ack), .probe_req(probe_req), .probe_done(probe_done), .probe_go(probe_go)
    );

    // Scenario vector: {kind, halt_lp, stpg_lp, mask[1:0], exp_disc, exp_sr, exp_kind}
    localparam int NCASE = 7;
    localparam logic [7:0] CASES [NCASE] = '{
        8'b0_0_0_11_0_0_0,
        8'b0_1_0_11_1_0_0,
        8'b1_0_0_01_0_0_1,
        8'b1_0_0_11_0_0_1,
        8'b1_0_1_11_1_1_1,
        8'b1_0_1_10_1_1_1,
        8'b0_1_1_11_1_0_0
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Responder: ready follows connect, acks copy requests; then advance one cycle.
    task automatic step_auto();
        cpu_ready = cpu_connect;
        sr_ack    = sr_req;
        fwd_ack   = fwd_req;
        @(negedge clk);
    endtask

    task automatic pulse_sc(input logic kind, input logic cpu);
        sc_valid = 1'b1; sc_kind = kind; sc_cpu = cpu;
        @(negedge clk);
        sc_valid = 1'b0;
    endtask

    task automatic pulse_bus();
        bus_activity = 1'b1;
        @(negedge clk);
        bus_activity = 1'b0;
    endtask

    task automatic run_case(input int idx);
        logic [7:0] v;
        string tg;
        int last, t_disc, t_sr, t_fwd;
        logic fk;
        v = CASES[idx];
        cfg_halt_lp = v[6]; cfg_stpg_lp = v[5]; cfg_cpu_mask = v[4:3];
        if (v[7] == 1'b0) tg = v[6] ? "R3" : "R2";
        else              tg = v[5] ? "R6" : "R5";
        if (v[7] == 1'b0) begin
            pulse_sc(1'b0, 1'b0);
        end else begin
            last = v[4] ? 1 : 0;
            for (int c = 0; c <= last; c++) begin
                pulse_sc(1'b1, c[0]);
                if (c != last)
                    chk("R4 no action before all present", {6'd0, fwd_req, cpu_connect}, 8'h01);
            end
        end
        t_disc = -1; t_sr = -1; t_fwd = -1; fk = 1'b0;
        for (int t = 0; t < 10; t++) begin
            if (!cpu_connect && t_disc < 0) t_disc = t;
            if (sr_req && t_sr < 0) t_sr = t;
            if (fwd_req && t_fwd < 0) begin t_fwd = t; fk = fwd_kind; end
            step_auto();
        end
        chk({tg, " disconnect seen"}, {7'd0, t_disc >= 0}, {7'd0, v[2]});
        chk({tg, " self-refresh seen"}, {7'd0, t_sr >= 0}, {7'd0, v[1]});
        chk({tg, " forward seen"}, {7'd0, t_fwd >= 0}, 8'h01);
        chk({tg, " forward kind"}, {7'd0, fk}, {7'd0, v[0]});
        if (v[2]) chk({tg, " disconnect before forward"}, {7'd0, t_disc < t_fwd}, 8'h01);
        if (v[1]) chk({tg, " order disc<sr<fwd"}, {7'd0, (t_disc < t_sr) && (t_sr < t_fwd)}, 8'h01);
        chk({tg, " end state"}, {5'd0, cpu_connect, sr_req, fwd_req}, {5'd0, !v[2], 2'b00});
        if (v[2]) begin
            pulse_bus();
            for (int t = 0; t < 4; t++) step_auto();
            chk("R10 wake returns to normal", {5'd0, cpu_connect, sr_req, fwd_req}, 8'h04);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset state", {4'd0, cpu_connect, sr_req, fwd_req, probe_go}, 8'h08);

        // Vector table walk.
        for (int i = 0; i < NCASE; i++) run_case(i);

        // R11 and R7: ready held high, then forward ack held back.
        cfg_halt_lp = 1'b1; cfg_stpg_lp = 1'b0; cfg_cpu_mask = 2'b11;
        pulse_sc(1'b0, 1'b0);
        for (int t = 0; t < 3; t++) begin
            chk("R11 wait for ready low", {6'd0, cpu_connect, fwd_req}, 8'h00);
            @(negedge clk);
        end
        cpu_ready = 1'b0;
        @(negedge clk);
        chk("R3 forward after ready low", {7'd0, fwd_req}, 8'h01);
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            chk("R7 forward held", {6'd0, fwd_req, fwd_kind}, 8'h02);
        end
        fwd_ack = 1'b1;
        @(negedge clk);
        fwd_ack = 1'b0;
        chk("R3 disconnected after ack", {6'd0, cpu_connect, fwd_req}, 8'h00);

        // R8: probe-triggered reconnect.
        probe_req = 1'b1;
        @(negedge clk);
        chk("R8 connect rises", {6'd0, cpu_connect, probe_go}, 8'h02);
        @(negedge clk);
        chk("R8 no grant before ready", {7'd0, probe_go}, 8'h00);
        cpu_ready = 1'b1;
        @(negedge clk);
        chk("R8 grant after ready", {7'd0, probe_go}, 8'h01);
        @(negedge clk);
        chk("R8 grant held", {7'd0, probe_go}, 8'h01);
        probe_done = 1'b1; probe_req = 1'b0;
        @(negedge clk);
        probe_done = 1'b0;
        chk("R9 redisconnect", {6'd0, cpu_connect, probe_go}, 8'h00);
        begin
            logic any_req;
            any_req = 1'b0;
            for (int t = 0; t < 5; t++) begin
                any_req = any_req | sr_req | fwd_req;
                step_auto();
            end
            chk("R9 no repeat requests", {6'd0, any_req, cpu_connect}, 8'h00);
        end

        // R10: bus activity during a probe ends the episode.
        probe_req = 1'b1;
        step_auto(); step_auto();
        chk("R8 second probe granted", {7'd0, probe_go}, 8'h01);
        pulse_bus();
        probe_done = 1'b1; probe_req = 1'b0;
        @(negedge clk);
        probe_done = 1'b0;
        for (int t = 0; t < 3; t++) step_auto();
        chk("R10 normal after probe wake", {4'd0, cpu_connect, sr_req, fwd_req, probe_go}, 8'h08);

        // R4: duplicate arrivals and clearing between rounds.
        cfg_halt_lp = 1'b0; cfg_stpg_lp = 1'b0; cfg_cpu_mask = 2'b11;
        pulse_sc(1'b1, 1'b0);
        pulse_sc(1'b1, 1'b0);
        chk("R4 duplicate ignored", {7'd0, fwd_req}, 8'h00);
        pulse_sc(1'b1, 1'b1);
        chk("R5 forward stop grant", {5'd0, fwd_req, fwd_kind, cpu_connect}, 8'h07);
        step_auto(); step_auto();
        pulse_sc(1'b1, 1'b1);
        chk("R4 flags cleared", {7'd0, fwd_req}, 8'h00);
        pulse_sc(1'b1, 1'b0);
        chk("R4 second round completes", {7'd0, fwd_req}, 8'h01);
        step_auto(); step_auto();

        // R7: self-refresh request held until ack.
        cfg_stpg_lp = 1'b1;
        pulse_sc(1'b1, 1'b0);
        pulse_sc(1'b1, 1'b1);
        cpu_ready = 1'b0;
        @(negedge clk);
        for (int t = 0; t < 3; t++) begin
            chk("R7 self-refresh held", {6'd0, sr_req, fwd_req}, 8'h02);
            @(negedge clk);
        end
        sr_ack = 1'b1;
        @(negedge clk);
        sr_ack = 1'b0;
        chk("R6 forward after sr ack", {6'd0, sr_req, fwd_req}, 8'h01);
        step_auto(); step_auto();
        pulse_bus();
        for (int t = 0; t < 3; t++) step_auto();
        chk("R10 normal after wake", {5'd0, cpu_connect, sr_req, fwd_req}, 8'h04);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule